// File: doc/BRIEF.md
# Serial EEPROM Command and Page-Write Controller

This block is the byte-level protocol engine of a 256-byte serial memory slave on a single-wire bus. A bit-level transceiver in front of it recovers bit timing. It delivers the following as single-cycle pulses:

- start-header completion;
- received bytes;
- the master's acknowledge bit after each byte, where continue is 1 and stop is 0;
- standby pulses.

For every master acknowledge, the engine returns a single slave acknowledge decision, which is positive or negative. When the master is reading, it supplies the byte the transceiver must send next.

Inside, the engine does the following:

- checks the device address;
- decodes the command byte;
- keeps the memory address pointer and the write-enable latch;
- collects up to one page of data in a page buffer;
- runs a write cycle as a counted busy delay before the buffer is committed to a register-based array.

A fixed pattern of errors sends the engine into an idle state. In that state all traffic is ignored until the next standby pulse.

Top module: `uee_proto_engine`

## Requirements
- R1: After a start header, the first byte must be 0xA0. A mismatch gives a negative slave acknowledge and enters idle. A match followed by master stop gives a positive acknowledge and returns to waiting for a header.
- R2: The accepted command codes are 0x03 random read, 0x06 read-at-pointer, 0x6C write, 0x96 set write latch, 0x91 clear write latch, 0x05 status read, 0x6E status write, 0x6D fill with 0x00 and 0x67 fill with 0xFF. Any other code gets a negative acknowledge and enters idle. A master stop where more bytes are needed also gets a negative acknowledge and enters idle.
- R3: Random read and write take two address bytes, high byte first. The pointer loads from the low byte at its continue acknowledge. On read, each acknowledge advances the pointer by one and wraps from 0xFF to 0x00. Continue returns the next byte; stop ends the command.
- R4: Read-at-pointer begins at the pointer left by the previous command.
- R5: On write, only the low PAGE_W pointer bits advance. Data past the end of a 16-byte page wraps to that page's start and does not enter the next page.
- R6: A write cycle starts only on a master stop after at least one data byte, and only with the write latch set. It then clears the latch. A stop right after the address gives a negative acknowledge, enters idle and writes nothing.
- R7: A standby pulse in place of the acknowledge after a data byte aborts the write. The pointer is left unchanged.
- R8: The latch set/clear commands and the two fill commands need a master stop straight after the command byte. Status write needs a stop straight after its data byte. A continue at these points gives a negative acknowledge and enters idle.
- R9: While a write cycle runs, random read, read-at-pointer, write, status write and both fills are refused with a negative acknowledge. Status read is still served.
- R10: `busy` rises on the clock after the committing stop. It lasts exactly WR_CYCLES cycles for page and status writes and exactly FILL_CYCLES cycles for a fill.
- R11: The status byte is {4'b0000, protect[1:0] in bits 3:2, write latch in bit 1, busy in bit 0}. It is sent again on each continue acknowledge.
- R12: In idle, headers, bytes and acknowledges produce no acknowledge and no transmit byte. Only a standby pulse leaves idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hdr_done | input | 1 | Start header finished |
| rx_valid | input | 1 | Byte received from master |
| rx_byte | input | 8 | Received byte |
| ack_valid | input | 1 | Master acknowledge bit received |
| ack_mak | input | 1 | 1 = continue, 0 = stop |
| stby | input | 1 | Standby pulse seen |
| sak_valid | output | 1 | Slave acknowledge decision valid |
| sak_ok | output | 1 | 1 = positive acknowledge |
| tx_valid | output | 1 | Byte ready to transmit |
| tx_byte | output | 8 | Byte to transmit |
| idle | output | 1 | Engine ignores traffic until standby |
| busy | output | 1 | Write cycle in progress |

## Verification
The acknowledge decision, the transmit byte and the idle flag are all registered. They appear one clock after the cycle carrying the master acknowledge pulse. The bench raises each pulse on a falling edge and samples on the next falling edge, so one register stage separates cause and check.

`busy` rises together with the committing acknowledge. The bench counts falling edges while it stays high and compares the count with the parameter for that operation.

Memory effects are observed only one command later, through reads at the ports.

// File: rtl/uee_pkg.sv
package uee_pkg;
  localparam logic [7:0] DEV_ID = 8'hA0;

  typedef enum logic [3:0] {
    CM_BAD, CM_RD, CM_RDCUR, CM_WR, CM_WEN, CM_WDIS,
    CM_STRD, CM_STWR, CM_CLR, CM_SET
  } cmd_e;

  typedef enum logic [3:0] {
    S_WAIT, S_DEV, S_CMD, S_AHI, S_ALO, S_WDAT, S_RDAT, S_SRD, S_SRW, S_IDLE
  } st_e;

  typedef enum logic [1:0] {K_PAGE, K_STAT, K_CLR, K_SET} kind_e;
endpackage

// File: rtl/uee_cmd_decode.sv
module uee_cmd_decode
  import uee_pkg::*;
(
  input  logic [7:0] code,
  output cmd_e       cmd,
  output logic       locked
);
  always_comb begin
    unique case (code)
      8'h03:   cmd = CM_RD;
      8'h06:   cmd = CM_RDCUR;
      8'h6C:   cmd = CM_WR;
      8'h96:   cmd = CM_WEN;
      8'h91:   cmd = CM_WDIS;
      8'h05:   cmd = CM_STRD;
      8'h6E:   cmd = CM_STWR;
      8'h6D:   cmd = CM_CLR;
      8'h67:   cmd = CM_SET;
      default: cmd = CM_BAD;
    endcase
    // refused while a write cycle runs
    locked = (cmd == CM_RD) || (cmd == CM_RDCUR) || (cmd == CM_WR) ||
             (cmd == CM_STWR) || (cmd == CM_CLR) || (cmd == CM_SET);
  end
endmodule

// File: rtl/uee_wr_timer.sv
module uee_wr_timer #(
  parameter int unsigned SHORT = 40,
  parameter int unsigned LONG  = 80
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic long_sel,
  output logic busy,
  output logic done
);
  localparam int unsigned CW = $clog2(LONG + 1);
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (start)              cnt_d = long_sel ? CW'(LONG) : CW'(SHORT);
    else if (cnt_q != '0)   cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;

  assign busy = (cnt_q != '0);
  assign done = (cnt_q == CW'(1));
endmodule

// File: rtl/uee_array.sv
module uee_array #(
  parameter int unsigned AW = 8,
  parameter int unsigned PW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          buf_we,
  input  logic [PW-1:0] buf_idx,
  input  logic [AW-PW-1:0] buf_page,
  input  logic [7:0]    buf_data,
  input  logic          buf_clr,
  input  logic          commit,
  input  logic          fill,
  input  logic [7:0]    fill_val,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data
);
  localparam int unsigned DEPTH = 1 << AW;
  localparam int unsigned PSIZE = 1 << PW;

  logic [7:0]       mem [DEPTH];
  logic [7:0]       pbuf [PSIZE];
  logic [PSIZE-1:0] mask_q;
  logic [AW-PW-1:0] page_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) mask_q <= '0;
    else if (buf_clr || commit) mask_q <= '0;
    else if (buf_we) mask_q[buf_idx] <= 1'b1;

  always_ff @(posedge clk)
    if (buf_we) begin
      pbuf[buf_idx] <= buf_data;
      page_q        <= buf_page;
    end

  always_ff @(posedge clk)
    if (fill) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= fill_val;
    end else if (commit) begin
      for (int j = 0; j < PSIZE; j++)
        if (mask_q[j]) mem[{page_q, PW'(j)}] <= pbuf[j];
    end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/uee_proto_engine.sv
module uee_proto_engine
  import uee_pkg::*;
#(
  parameter int unsigned AW          = 8,
  parameter int unsigned PW          = 4,
  parameter int unsigned WR_CYCLES   = 40,
  parameter int unsigned FILL_CYCLES = 80
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hdr_done,
  input  logic       rx_valid,
  input  logic [7:0] rx_byte,
  input  logic       ack_valid,
  input  logic       ack_mak,
  input  logic       stby,
  output logic       sak_valid,
  output logic       sak_ok,
  output logic       tx_valid,
  output logic [7:0] tx_byte,
  output logic       idle,
  output logic       busy
);
  logic [1:0] rsync_q;
  logic       rst_i;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  assign rst_i = rsync_q[1];

  st_e   st_q, st_d;
  cmd_e  cmd_q, cmd_d, dec_cmd;
  kind_e kind_q, kind_d;
  logic  got_q, got_d, ok_q, ok_d, wel_q, wel_d;
  logic  [1:0] bp_q, bp_d;
  logic  [7:0] hold_q, hold_d, txb_q, txb_d;
  logic  [AW-1:0] ptr_q, ptr_d, rd_addr;
  logic  sakv_d, sako_d, txv_d, sakv_q, sako_q, txv_q;
  logic  dec_locked, buf_we, buf_clr, wr_start, wr_long, wr_done, xmit;
  logic  [7:0] rd_data, status;

  uee_cmd_decode u_dec (.code(hold_d), .cmd(dec_cmd), .locked(dec_locked));

  uee_wr_timer #(.SHORT(WR_CYCLES), .LONG(FILL_CYCLES)) u_tmr (
    .clk(clk), .rst_n(rst_i), .start(wr_start), .long_sel(wr_long),
    .busy(busy), .done(wr_done));

  uee_array #(.AW(AW), .PW(PW)) u_arr (
    .clk(clk), .rst_n(rst_i), .buf_we(buf_we), .buf_idx(ptr_q[PW-1:0]),
    .buf_page(ptr_q[AW-1:PW]), .buf_data(hold_q), .buf_clr(buf_clr),
    .commit(wr_done && kind_q == K_PAGE),
    .fill(wr_done && (kind_q == K_CLR || kind_q == K_SET)),
    .fill_val((kind_q == K_SET) ? 8'hFF : 8'h00),
    .rd_addr(rd_addr), .rd_data(rd_data));

  assign status = {4'b0000, bp_q, wel_q, busy};
  assign xmit   = (st_q == S_RDAT) || (st_q == S_SRD);

  always_comb begin
    st_d = st_q; cmd_d = cmd_q; kind_d = kind_q; got_d = got_q; ok_d = ok_q;
    wel_d = wel_q; bp_d = bp_q; hold_d = hold_q; ptr_d = ptr_q; txb_d = txb_q;
    sakv_d = 1'b0; sako_d = 1'b0; txv_d = 1'b0;
    rd_addr = ptr_q; buf_we = 1'b0; buf_clr = 1'b0; wr_start = 1'b0; wr_long = 1'b0;
    if (stby) begin
      st_d = S_WAIT; got_d = 1'b0;
    end else if (st_q == S_WAIT) begin
      if (hdr_done) begin st_d = S_DEV; got_d = 1'b0; end
    end else if (st_q != S_IDLE) begin
      if (rx_valid) begin
        if (got_q || xmit) st_d = S_IDLE;            // out of step with master
        else begin
          got_d = 1'b1; hold_d = rx_byte; ok_d = 1'b1;
          if (st_q == S_DEV) ok_d = (rx_byte == DEV_ID);
          else if (st_q == S_CMD) begin
            cmd_d = dec_cmd;
            ok_d  = (dec_cmd != CM_BAD) && !(busy && dec_locked);
          end
        end
      end else if (ack_valid) begin
        sakv_d = 1'b1; got_d = 1'b0; st_d = S_IDLE;  // default: refuse and idle
        if (xmit || (got_q && ok_q)) begin
          unique case (st_q)
            S_DEV: begin sako_d = 1'b1; st_d = ack_mak ? S_CMD : S_WAIT; end
            S_CMD: begin
              unique case (cmd_q)
                CM_RD, CM_WR, CM_STWR:
                  if (ack_mak) begin sako_d = 1'b1; st_d = (cmd_q == CM_STWR) ? S_SRW : S_AHI; end
                CM_RDCUR:
                  if (ack_mak) begin sako_d = 1'b1; st_d = S_RDAT; txv_d = 1'b1; txb_d = rd_data; end
                CM_STRD:
                  if (ack_mak) begin sako_d = 1'b1; st_d = S_SRD; txv_d = 1'b1; txb_d = status; end
                CM_WEN, CM_WDIS:
                  if (!ack_mak) begin sako_d = 1'b1; st_d = S_WAIT; wel_d = (cmd_q == CM_WEN); end
                CM_CLR, CM_SET:
                  if (!ack_mak) begin
                    sako_d = 1'b1; st_d = S_WAIT;
                    if (wel_q) begin
                      wr_start = 1'b1; wr_long = 1'b1; wel_d = 1'b0;
                      kind_d = (cmd_q == CM_SET) ? K_SET : K_CLR;
                    end
                  end
                default: ;
              endcase
            end
            S_AHI: if (ack_mak) begin sako_d = 1'b1; st_d = S_ALO; end
            S_ALO: if (ack_mak) begin
              sako_d = 1'b1; ptr_d = hold_q[AW-1:0];
              if (cmd_q == CM_RD) begin
                st_d = S_RDAT; rd_addr = hold_q[AW-1:0]; txv_d = 1'b1; txb_d = rd_data;
              end else begin
                st_d = S_WDAT; buf_clr = 1'b1;
              end
            end
            S_WDAT: begin
              sako_d = 1'b1; buf_we = 1'b1;
              ptr_d  = {ptr_q[AW-1:PW], ptr_q[PW-1:0] + PW'(1)};
              st_d   = ack_mak ? S_WDAT : S_WAIT;
              if (!ack_mak && wel_q) begin wr_start = 1'b1; kind_d = K_PAGE; wel_d = 1'b0; end
            end
            S_RDAT: begin
              sako_d = 1'b1; ptr_d = ptr_q + AW'(1);
              if (ack_mak) begin
                st_d = S_RDAT; rd_addr = ptr_q + AW'(1); txv_d = 1'b1; txb_d = rd_data;
              end else st_d = S_WAIT;
            end
            S_SRD: begin
              sako_d = 1'b1;
              if (ack_mak) begin st_d = S_SRD; txv_d = 1'b1; txb_d = status; end
              else st_d = S_WAIT;
            end
            S_SRW: if (!ack_mak) begin
              sako_d = 1'b1; st_d = S_WAIT;
              if (wel_q) begin bp_d = hold_q[3:2]; wel_d = 1'b0; wr_start = 1'b1; kind_d = K_STAT; end
            end
            default: ;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_i)
    if (!rst_i) begin
      st_q <= S_WAIT; cmd_q <= CM_BAD; kind_q <= K_PAGE; got_q <= 1'b0; ok_q <= 1'b0;
      wel_q <= 1'b0; bp_q <= 2'b00; hold_q <= 8'h00; ptr_q <= '0; txb_q <= 8'h00;
      sakv_q <= 1'b0; sako_q <= 1'b0; txv_q <= 1'b0;
    end else begin
      st_q <= st_d; cmd_q <= cmd_d; kind_q <= kind_d; got_q <= got_d; ok_q <= ok_d;
      wel_q <= wel_d; bp_q <= bp_d; hold_q <= hold_d; ptr_q <= ptr_d; txb_q <= txb_d;
      sakv_q <= sakv_d; sako_q <= sako_d; txv_q <= txv_d;
    end

  assign sak_valid = sakv_q;
  assign sak_ok    = sako_q;
  assign tx_valid  = txv_q;
  assign tx_byte   = txb_q;
  assign idle      = (st_q == S_IDLE);
endmodule

// File: rtl/uee_proto_engine_chk.sv
module uee_proto_engine_chk #(
  parameter int unsigned LONG = 80
) (
  input logic clk,
  input logic rst_n,
  input logic ack_valid,
  input logic ack_mak,
  input logic stby,
  input logic sak_valid,
  input logic sak_ok,
  input logic tx_valid,
  input logic idle,
  input logic busy
);
  int unsigned bcnt;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)    bcnt <= 0;
    else if (busy) bcnt <= bcnt + 1;
    else           bcnt <= 0;

  a_r2_sak_follows_ack: assert property (@(posedge clk) disable iff (!rst_n)
    sak_valid |-> $past(ack_valid));
  a_r2_nosak_goes_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (sak_valid && !sak_ok) |-> idle);
  a_r6_write_on_stop: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(ack_valid && !ack_mak));
  a_r11_tx_on_continue: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> $past(ack_valid && ack_mak));
  a_r12_idle_silent: assert property (@(posedge clk) disable iff (!rst_n)
    $past(idle) |-> (!sak_valid && !tx_valid));
  a_r12_idle_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && !stby) |=> idle);
  a_r10_busy_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    bcnt <= LONG);
endmodule

bind uee_proto_engine uee_proto_engine_chk #(.LONG(FILL_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .ack_valid(ack_valid), .ack_mak(ack_mak), .stby(stby),
  .sak_valid(sak_valid), .sak_ok(sak_ok), .tx_valid(tx_valid), .idle(idle), .busy(busy));

// File: tb/uee_proto_engine_test.sv
module uee_proto_engine_test;
  localparam int WR = 40;
  localparam int FL = 80;
  // {command byte, master acknowledge, expected slave acknowledge}
  localparam logic [9:0] VEC [0:11] = '{
    {8'h96, 1'b0, 1'b1}, {8'h91, 1'b0, 1'b1}, {8'h96, 1'b1, 1'b0}, {8'h00, 1'b1, 1'b0},
    {8'hFF, 1'b0, 1'b0}, {8'h05, 1'b0, 1'b0}, {8'h6D, 1'b1, 1'b0}, {8'h67, 1'b1, 1'b0},
    {8'h03, 1'b0, 1'b0}, {8'h6C, 1'b0, 1'b0}, {8'h06, 1'b0, 1'b0}, {8'h6E, 1'b0, 1'b0}};

  logic clk = 1'b0, rst_n = 1'b0;
  logic hdr_done = 1'b0, rx_valid = 1'b0, ack_valid = 1'b0, ack_mak = 1'b0, stby = 1'b0;
  logic [7:0] rx_byte = 8'h00;
  logic sak_valid, sak_ok, tx_valid, idle, busy;
  logic [7:0] tx_byte;
  int checks = 0, fails = 0;
  logic r_sv, r_sok, r_tv;
  logic [7:0] r_tb;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  uee_proto_engine #(.WR_CYCLES(WR), .FILL_CYCLES(FL)) uut (
    .clk(clk), .rst_n(rst_n), .hdr_done(hdr_done), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .ack_valid(ack_valid), .ack_mak(ack_mak), .stby(stby), .sak_valid(sak_valid),
    .sak_ok(sak_ok), .tx_valid(tx_valid), .tx_byte(tx_byte), .idle(idle), .busy(busy));

  task automatic chk(input bit good, input string tag, input int act, input int exp);
    checks++;
    if (!good) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic hdr();
    @(negedge clk); hdr_done = 1'b1; @(negedge clk); hdr_done = 1'b0;
  endtask
  task automatic stbyp();
    @(negedge clk); stby = 1'b1; @(negedge clk); stby = 1'b0;
  endtask
  task automatic sbyte(input logic [7:0] b);
    @(negedge clk); rx_valid = 1'b1; rx_byte = b; @(negedge clk); rx_valid = 1'b0;
  endtask
  task automatic ack(input logic m);
    @(negedge clk); ack_valid = 1'b1; ack_mak = m;
    @(negedge clk); ack_valid = 1'b0;
    r_sv = sak_valid; r_sok = sak_ok; r_tv = tx_valid; r_tb = tx_byte;
  endtask
  task automatic sel(input logic [7:0] c);
    stbyp(); hdr(); sbyte(8'hA0); ack(1'b1); sbyte(c);
  endtask
  task automatic addr(input logic [7:0] a);
    ack(1'b1); sbyte(8'h00); ack(1'b1); sbyte(a); ack(1'b1);
  endtask
  task automatic wait_busy(output int n);
    n = 0;
    while (busy && n < 1000) begin n++; @(negedge clk); end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!idle && !busy, "reset idle/busy", {idle, busy}, 0);
    chk(!sak_valid && !tx_valid, "reset outputs", {sak_valid, tx_valid}, 0);

    // R1 address mismatch, then R12 idle ignores a full selection
    stbyp(); hdr(); sbyte(8'hA2); ack(1'b1);
    chk(r_sv && !r_sok && idle, "R1 mismatch nosak+idle", {r_sv, r_sok, idle}, 3'b101);
    hdr(); sbyte(8'hA0); ack(1'b1);
    chk(!r_sv && idle, "R12 idle ignores traffic", {r_sv, idle}, 2'b01);
    stbyp();
    chk(!idle, "R12 standby leaves idle", idle, 0);
    stbyp(); hdr(); sbyte(8'hA0); ack(1'b0);
    chk(r_sv && r_sok && !idle, "R1 stop after address", {r_sv, r_sok, idle}, 3'b110);

    // R2 / R8 command table
    for (int i = 0; i < 12; i++) begin
      sel(VEC[i][9:2]); ack(VEC[i][1]);
      chk(r_sv && r_sok == VEC[i][0] && idle == !VEC[i][0], "R2 R8 command table",
          {r_sok, idle}, {VEC[i][0], !VEC[i][0]});
    end

    // fill with 0xFF, R9 refusals while busy, R11 status during busy
    sel(8'h96); ack(1'b0); sel(8'h67); ack(1'b0);
    chk(r_sok && busy, "R10 fill starts busy", {r_sok, busy}, 2'b11);
    sel(8'h03); ack(1'b1);
    chk(!r_sok, "R9 read refused while busy", r_sok, 0);
    sel(8'h6D); ack(1'b0);
    chk(!r_sok, "R9 fill refused while busy", r_sok, 0);
    sel(8'h05); ack(1'b1);
    chk(r_tv && r_tb == 8'h01, "R11 status busy", r_tb, 8'h01);
    ack(1'b1);
    chk(r_tv && r_tb == 8'h01, "R11 status repeat", r_tb, 8'h01);
    ack(1'b0);
    chk(r_sok && !r_tv, "R11 status stop", r_sok, 1);
    wait_busy(n);

    // fill with 0x00, exact duration
    sel(8'h96); ack(1'b0); sel(8'h6D); ack(1'b0);
    wait_busy(n);
    chk(n == FL, "R10 fill duration", n, FL);

    // page write with wrap: 0x0E..0x0F then 0x00..0x01
    sel(8'h96); ack(1'b0); sel(8'h6C); addr(8'h0E);
    sbyte(8'h11); ack(1'b1); sbyte(8'h22); ack(1'b1);
    sbyte(8'h33); ack(1'b1); sbyte(8'h44); ack(1'b0);
    chk(r_sok && busy, "R6 write commits on stop", {r_sok, busy}, 2'b11);
    wait_busy(n);
    chk(n == WR, "R10 page write duration", n, WR);

    sel(8'h03); addr(8'h0E);
    chk(r_tv && r_tb == 8'h11, "R3 random read first", r_tb, 8'h11);
    ack(1'b1);
    chk(r_tb == 8'h22, "R3 sequential read", r_tb, 8'h22);
    ack(1'b1);
    chk(r_tb == 8'h00, "R5 next page untouched", r_tb, 8'h00);
    ack(1'b0);

    sel(8'h03); addr(8'hFF);
    chk(r_tb == 8'h00, "R3 read at top", r_tb, 8'h00);
    ack(1'b1);
    chk(r_tb == 8'h33, "R3 R5 wrap to zero", r_tb, 8'h33);
    ack(1'b0);
    sel(8'h06); ack(1'b1);
    chk(r_tv && r_tb == 8'h44, "R4 read at pointer", r_tb, 8'h44);
    ack(1'b0);

    // R6 stop before data
    sel(8'h96); ack(1'b0); sel(8'h6C); ack(1'b1); sbyte(8'h00); ack(1'b1); sbyte(8'h00); ack(1'b0);
    chk(!r_sok && idle && !busy, "R6 stop before data", {r_sok, idle, busy}, 3'b010);

    // R7 standby instead of acknowledge
    sel(8'h6C); addr(8'h00); sbyte(8'h55); stbyp();
    @(negedge clk);
    chk(!busy, "R7 abort no busy", busy, 0);
    sel(8'h06); ack(1'b1);
    chk(r_tb == 8'h33, "R7 pointer held, no write", r_tb, 8'h33);
    ack(1'b0);

    // R6 without latch
    sel(8'h91); ack(1'b0); sel(8'h6C); addr(8'h00); sbyte(8'h99); ack(1'b0);
    @(negedge clk);
    chk(r_sok && !busy, "R6 no latch no cycle", {r_sok, busy}, 2'b10);
    sel(8'h03); addr(8'h00);
    chk(r_tb == 8'h33, "R6 data unchanged", r_tb, 8'h33);
    ack(1'b0);

    // R8 status write with continue
    sel(8'h96); ack(1'b0); sel(8'h6E); ack(1'b1); sbyte(8'h0C); ack(1'b1);
    chk(!r_sok && idle, "R8 status write continue", {r_sok, idle}, 2'b01);
    sel(8'h6E); ack(1'b1); sbyte(8'h0C); ack(1'b0);
    chk(r_sok && busy, "R10 status write busy", {r_sok, busy}, 2'b11);
    wait_busy(n);
    chk(n == WR, "R10 status write duration", n, WR);
    sel(8'h05); ack(1'b1);
    chk(r_tb == 8'h0C, "R11 status layout", r_tb, 8'h0C);
    ack(1'b0);

    finished = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule